// File: doc/BRIEF.md
# Holdover Frequency Offset Engine

This block sits beside the loop of a digital PLL. It chooses the 24-bit frequency offset word that steers the oscillator once the loop stops tracking its input and falls into holdover. All offset words are two's-complement. One LSB is worth 0.000011 ppm, so the offset in ppm is the word times 0.000011.

While the loop is locked, the engine keeps two first-order IIR averages of the live frequency word: a slow one and a fast one. It also takes an instantaneous snapshot of the live word at the moment holdover begins. Three configuration bits pick the source. A manual bit forces a software-written register. Otherwise an averaging bit chooses between the frozen snapshot and an average, and a rate bit chooses between the slow and the fast average.

A separate read-back port returns either the written manual value or the average that the rate bit selects. This lets software take an average and later write it back as a manual value. The live word is also passed through unchanged for status.

Top module: `hold_offset_engine`

## Requirements
- R1: A cycle with `man_wr_en`=1 stores `man_wr_data` in the manual register. The new value is visible from the next cycle.
- R2: With `cfg_manual`=1, `holdover_offset` equals the manual register, whatever `cfg_auto_avg` and `cfg_fast_avg` hold.
- R3: With `cfg_manual`=0 and `cfg_auto_avg`=0, `holdover_offset` equals the live word sampled in the first clock cycle where `in_holdover` is 1 after being 0 (or after reset). `cfg_fast_avg` has no effect in this case.
- R4: With `cfg_manual`=0 and `cfg_auto_avg`=1, `holdover_offset` is the slow average when `cfg_fast_avg`=0 and the fast average when it is 1.
- R5: Each average keeps a signed accumulator `acc` of W+G bits, scaled by 2^G. On a cycle with `sample_tick`=1 and `in_holdover`=0, it updates as acc += ((x<<G) - acc) >>> K, where x is the live word. The average is acc >>> G. The slow filter uses K_SLOW (default 7) and the fast filter uses K_FAST (default 3), with G=16.
- R6: The first qualifying tick after reset loads acc = x<<G in place of the update, so that average equals the live word from the next cycle.
- R7: While `in_holdover`=1, neither average changes, even when ticks arrive.
- R8: `rd_value` returns the manual register when `rd_avg_sel`=0. When `rd_avg_sel`=1 it returns the slow average if `cfg_fast_avg`=0 and the fast average if it is 1.
- R9: `live_freq_status` equals `live_freq` in the same cycle.
- R10: A synchronous reset (`rst_n`=0) clears the manual register, both averages and the snapshot to zero.
- R11: The snapshot keeps its value through holdover, through locked periods and through re-lock, until the next entry into holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | Average update strobe |
| in_holdover | input | 1 | 1 = loop in holdover, 0 = locked |
| live_freq | input | 24 | Signed live frequency word from the loop |
| cfg_manual | input | 1 | Force the manual register as source |
| cfg_auto_avg | input | 1 | 0 = snapshot, 1 = average |
| cfg_fast_avg | input | 1 | 0 = slow average, 1 = fast average |
| man_wr_en | input | 1 | Write strobe for the manual register |
| man_wr_data | input | 24 | Value written to the manual register |
| rd_avg_sel | input | 1 | 0 = read manual register, 1 = read average |
| holdover_offset | output | 24 | Selected holdover offset word |
| rd_value | output | 24 | Read-back word |
| live_freq_status | output | 24 | Live frequency pass-through |

## Verification
The in-RTL assertions check five properties on every cycle: the averages stay frozen in holdover, the snapshot stays stable inside a holdover period, the preload copies the sample, the manual register takes each write, and the accumulator never overflows. Each of these is checked against whatever stimulus is running. Whether an average converges by the exact step law, and whether each decoding of the three configuration bits routes the right source, shows only in the bench. The bench does this by running a behavioural model under ramps, sign changes and repeated holdover entries, and comparing it with the design cycle by cycle.

// File: rtl/hoe_pkg.sv
// Package: shared source encoding and decode for the holdover offset engine.
// Assumes callers pass the three configuration bits exactly as received.
package hoe_pkg;

    typedef enum logic [1:0] {
        SRC_SNAP = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_FAST = 2'd2,
        SRC_MAN  = 2'd3
    } hoe_src_e;

    // Decode configuration bits into a holdover source; manual has priority.
    function automatic hoe_src_e decode_src(input logic manual,
                                            input logic auto_avg,
                                            input logic fast_avg);
        if (manual)         return SRC_MAN;
        else if (!auto_avg) return SRC_SNAP;
        else if (fast_avg)  return SRC_FAST;
        else                return SRC_SLOW;
    endfunction

endpackage

// File: rtl/hoe_iir_avg.sv
// Module: first-order leaky-integrator average of a signed word.
// Keeps an accumulator scaled by 2^GUARD and adds (x - avg) >> SHIFT on each
// enabled tick. The first enabled tick after reset preloads the sample.
// Assumes SHIFT < WIDTH + GUARD and an input that is stable at the tick edge.
module hoe_iir_avg #(
    parameter int WIDTH = 24,
    parameter int GUARD = 16,
    parameter int SHIFT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic signed [WIDTH-1:0] sample_in,
    output logic signed [WIDTH-1:0] avg_out
);
    localparam int AW = WIDTH + GUARD;

    logic signed [AW-1:0] acc_q;
    logic                 primed_q;
    logic signed [AW:0]   scaled_x;
    logic signed [AW:0]   diff;
    logic signed [AW:0]   step;
    logic signed [AW:0]   sum;

    // Form the scaled sample, the error term and the next accumulator value.
    always_comb begin
        scaled_x = {sample_in[WIDTH-1], sample_in, {GUARD{1'b0}}};
        diff     = scaled_x - {acc_q[AW-1], acc_q};
        step     = diff >>> SHIFT;
        sum      = {acc_q[AW-1], acc_q} + step;
    end

    // Accumulator register: preload on first tick, leaky update afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            primed_q <= 1'b0;
        end else if (upd_en) begin
            primed_q <= 1'b1;
            if (!primed_q) acc_q <= scaled_x[AW-1:0];
            else           acc_q <= sum[AW-1:0];
        end
    end

    assign avg_out = acc_q[AW-1:GUARD];

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(acc_q)); // R7
    AST_PRELOAD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_q) |-> avg_out == $past(sample_in)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && primed_q |-> sum[AW] == sum[AW-1]); // R5

endmodule

// File: rtl/hoe_snapshot.sv
// Module: captures the live word on entry into holdover.
// Entry is the first cycle where the holdover flag is 1 after being 0.
// The captured value is held until the next entry.
// Assumes the holdover flag is synchronous to clk.
module hoe_snapshot #(
    parameter int WIDTH = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    holdover,
    input  logic signed [WIDTH-1:0] live_in,
    output logic signed [WIDTH-1:0] snap_out
);
    logic                    hold_prev_q;
    logic signed [WIDTH-1:0] snap_q;
    logic                    entry;

    // Holdover entry detect.
    assign entry = holdover && !hold_prev_q;

    // Remember last holdover state and capture the word on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_prev_q <= 1'b0;
            snap_q      <= '0;
        end else begin
            hold_prev_q <= holdover;
            if (entry) snap_q <= live_in;
        end
    end

    assign snap_out = snap_q;

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !entry |=> $stable(snap_q)); // R11
    AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> snap_q == $past(live_in)); // R3

endmodule

// File: rtl/hoe_src_mux.sv
// Module: routes the holdover source and the read-back word.
// Purely combinational; all inputs come from registers or top-level ports.
module hoe_src_mux
    import hoe_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic             cfg_manual,
    input  logic             cfg_auto_avg,
    input  logic             cfg_fast_avg,
    input  logic             rd_avg_sel,
    input  logic [WIDTH-1:0] man_val,
    input  logic [WIDTH-1:0] snap_val,
    input  logic [WIDTH-1:0] slow_val,
    input  logic [WIDTH-1:0] fast_val,
    output logic [WIDTH-1:0] offset_out,
    output logic [WIDTH-1:0] rd_out
);
    hoe_src_e src;

    // Decode the configuration into a source selector.
    assign src = decode_src(cfg_manual, cfg_auto_avg, cfg_fast_avg);

    // Holdover offset multiplexer.
    always_comb begin
        unique case (src)
            SRC_MAN:  offset_out = man_val;
            SRC_SNAP: offset_out = snap_val;
            SRC_FAST: offset_out = fast_val;
            default:  offset_out = slow_val;
        endcase
    end

    // Read-back multiplexer: written value or the rate-selected average.
    always_comb begin
        if (!rd_avg_sel)      rd_out = man_val;
        else if (cfg_fast_avg) rd_out = fast_val;
        else                   rd_out = slow_val;
    end

endmodule

// File: rtl/hold_offset_engine.sv
// Module: holdover frequency offset engine, top level.
// Holds the manual offset register and two IIR averages (slow, fast), which
// run only while locked, plus a snapshot taken on holdover entry. It selects
// the holdover offset and the read-back word from these.
// Assumes all inputs are synchronous to clk and reset is active-low, synchronous.
module hold_offset_engine #(
    parameter int WIDTH  = 24,
    parameter int GUARD  = 16,
    parameter int K_SLOW = 7,
    parameter int K_FAST = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_tick,
    input  logic                    in_holdover,
    input  logic signed [WIDTH-1:0] live_freq,
    input  logic                    cfg_manual,
    input  logic                    cfg_auto_avg,
    input  logic                    cfg_fast_avg,
    input  logic                    man_wr_en,
    input  logic        [WIDTH-1:0] man_wr_data,
    input  logic                    rd_avg_sel,
    output logic        [WIDTH-1:0] holdover_offset,
    output logic        [WIDTH-1:0] rd_value,
    output logic        [WIDTH-1:0] live_freq_status
);
    localparam int NFILT = 2;

    logic              [WIDTH-1:0] man_q;
    logic signed       [WIDTH-1:0] snap;
    logic signed       [WIDTH-1:0] avg [NFILT];
    logic                          avg_en;

    // Manual offset register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         man_q <= '0;
        else if (man_wr_en) man_q <= man_wr_data;
    end

    // Averages advance only on ticks while locked.
    assign avg_en = sample_tick && !in_holdover;

    // Filter 0 is slow, filter 1 is fast.
    for (genvar i = 0; i < NFILT; i++) begin : g_filt
        localparam int KSEL = (i == 0) ? K_SLOW : K_FAST;
        hoe_iir_avg #(.WIDTH(WIDTH), .GUARD(GUARD), .SHIFT(KSEL)) u_avg (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en    (avg_en),
            .sample_in (live_freq),
            .avg_out   (avg[i])
        );
    end

    hoe_snapshot #(.WIDTH(WIDTH)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .holdover (in_holdover),
        .live_in  (live_freq),
        .snap_out (snap)
    );

    hoe_src_mux #(.WIDTH(WIDTH)) u_mux (
        .cfg_manual   (cfg_manual),
        .cfg_auto_avg (cfg_auto_avg),
        .cfg_fast_avg (cfg_fast_avg),
        .rd_avg_sel   (rd_avg_sel),
        .man_val      (man_q),
        .snap_val     (snap),
        .slow_val     (avg[0]),
        .fast_val     (avg[1]),
        .offset_out   (holdover_offset),
        .rd_out       (rd_value)
    );

    assign live_freq_status = live_freq;

    AST_MAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        man_wr_en |=> man_q == $past(man_wr_data)); // R1
    AST_MAN_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_manual && !rd_avg_sel |-> holdover_offset == rd_value); // R2
    AST_AVG_READ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_manual && cfg_auto_avg && rd_avg_sel |-> holdover_offset == rd_value); // R4
    AST_AVG_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_holdover |=> $stable(avg[0]) && $stable(avg[1])); // R7

endmodule

// File: tb/tb_hold_offset_engine.sv
module tb_hold_offset_engine;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 24;
    localparam int G  = 16;
    localparam int KS = 7;
    localparam int KF = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic sample_tick = 0;
    logic in_holdover = 0;
    logic signed [W-1:0] live_freq = '0;
    logic cfg_manual = 0, cfg_auto_avg = 1, cfg_fast_avg = 0;
    logic man_wr_en = 0;
    logic [W-1:0] man_wr_data = '0;
    logic rd_avg_sel = 0;
    logic [W-1:0] holdover_offset, rd_value, live_freq_status;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    hold_offset_engine #(.WIDTH(W), .GUARD(G), .K_SLOW(KS), .K_FAST(KF)) dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
        .in_holdover(in_holdover), .live_freq(live_freq),
        .cfg_manual(cfg_manual), .cfg_auto_avg(cfg_auto_avg),
        .cfg_fast_avg(cfg_fast_avg), .man_wr_en(man_wr_en),
        .man_wr_data(man_wr_data), .rd_avg_sel(rd_avg_sel),
        .holdover_offset(holdover_offset), .rd_value(rd_value),
        .live_freq_status(live_freq_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model state
    longint m_man, m_snap, m_acc_s, m_acc_f;
    bit m_primed_s, m_primed_f, m_hprev;

    function automatic longint sx(input logic [W-1:0] v);
        return longint'(signed'(v));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_man = 0; m_snap = 0; m_acc_s = 0; m_acc_f = 0;
            m_primed_s = 0; m_primed_f = 0; m_hprev = 0;
        end else begin
            longint x;
            x = sx(live_freq);
            if (man_wr_en) m_man = sx(man_wr_data);
            if (in_holdover && !m_hprev) m_snap = x;
            m_hprev = in_holdover;
            if (sample_tick && !in_holdover) begin
                if (!m_primed_s) m_acc_s = x <<< G;
                else m_acc_s = m_acc_s + (((x <<< G) - m_acc_s) >>> KS);
                if (!m_primed_f) m_acc_f = x <<< G;
                else m_acc_f = m_acc_f + (((x <<< G) - m_acc_f) >>> KF);
                m_primed_s = 1; m_primed_f = 1;
            end
        end
    end

    function automatic longint slow_avg(); return m_acc_s >>> G; endfunction
    function automatic longint fast_avg(); return m_acc_f >>> G; endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            longint e_off, e_rd;
            string tag;
            if (cfg_manual)        begin e_off = m_man;      tag = "R2"; end
            else if (!cfg_auto_avg) begin e_off = m_snap;     tag = "R3"; end
            else if (cfg_fast_avg)  begin e_off = fast_avg(); tag = "R4/R5 fast"; end
            else                    begin e_off = slow_avg(); tag = "R4/R5 slow"; end
            if (!rd_avg_sel) e_rd = m_man;
            else e_rd = cfg_fast_avg ? fast_avg() : slow_avg();
            check(tag, sx(holdover_offset), e_off);
            check("R8 readback", sx(rd_value), e_rd);
            check("R9 status", sx(live_freq_status), sx(live_freq));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic run_locked(input int n, input int base, input int slope);
        for (int i = 0; i < n; i++) begin
            live_freq   = W'(base + i*slope);
            sample_tick = (i % 3 == 0);
            step(1);
        end
        sample_tick = 0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint before_s, before_f;
        step(3);
        rst_n = 1; #1;
        // R10: reset state
        @(negedge clk);
        check("R10 offset", sx(holdover_offset), 0);
        rd_avg_sel = 1;
        @(negedge clk);
        check("R10 avg", sx(rd_value), 0);
        @(posedge clk); #1;

        // R6: first tick preloads
        live_freq = 24'sd1000; sample_tick = 1; step(1); sample_tick = 0;
        @(negedge clk);
        check("R6 slow preload", sx(rd_value), 1000);
        @(posedge clk); #1;

        // R5: signed ramp through negative values, rate bit toggled
        run_locked(150, -5000, 37);
        cfg_fast_avg = 1;
        run_locked(150, 200000, -2100);
        cfg_fast_avg = 0;

        // R1: manual write
        man_wr_en = 1; man_wr_data = 24'h123456; step(1); man_wr_en = 0;
        rd_avg_sel = 0;
        @(negedge clk);
        check("R1 manual write", rd_value, 24'h123456);
        @(posedge clk); #1;

        // R3: snapshot at holdover entry, rate bit ignored
        cfg_auto_avg = 0;
        live_freq = -24'sd777; in_holdover = 1; step(1);
        live_freq = 24'sd9999; step(1);
        @(negedge clk);
        check("R3 snapshot", sx(holdover_offset), -777);
        cfg_fast_avg = 1; #1;
        check("R3 fast ignored", sx(holdover_offset), -777);
        @(posedge clk); #1;

        // R7: averages frozen in holdover despite ticks
        rd_avg_sel = 1; cfg_fast_avg = 0; #1;
        before_s = sx(rd_value);
        cfg_fast_avg = 1; #1;
        before_f = sx(rd_value);
        for (int i = 0; i < 30; i++) begin
            sample_tick = 1; live_freq = W'(i*5000); step(1);
        end
        sample_tick = 0;
        @(negedge clk);
        check("R7 fast frozen", sx(rd_value), before_f);
        cfg_fast_avg = 0; #1;
        check("R7 slow frozen", sx(rd_value), before_s);
        @(posedge clk); #1;

        // R2: manual overrides other bits
        cfg_manual = 1;
        for (int c = 0; c < 4; c++) begin
            cfg_auto_avg = c[0]; cfg_fast_avg = c[1]; #1;
            check("R2 manual priority", holdover_offset, 24'h123456);
        end
        cfg_manual = 0; cfg_auto_avg = 1;
        step(1);

        // R11: re-lock, snapshot held, then new entry
        in_holdover = 0;
        run_locked(60, 400000, 0);
        cfg_auto_avg = 0; #1;
        check("R11 snapshot held", sx(holdover_offset), -777);
        live_freq = 24'sd31415; in_holdover = 1; step(2);
        @(negedge clk);
        check("R11 new snapshot", sx(holdover_offset), 31415);
        @(posedge clk); #1;
        cfg_auto_avg = 1; cfg_fast_avg = 1; step(5);
        in_holdover = 0;
        run_locked(40, -300000, 11);
        step(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule